// File: doc/BRIEF.md
# Named Split-Phase Barrier Unit

This unit synchronises a fixed group of processors through a set of named barriers. Each processor has its own arrive port and its own wait port, and each request carries a barrier ID. An arrive only records that the processor has finished its part of the current phase, so the processor can carry on with other work. A wait request asks to be held until the phase that the processor joined has completed. While it is held, the processor's stall output stays high.

Every barrier ID keeps one arrival bit per processor and a one-bit phase value. A barrier completes at the clock edge where the last missing arrival is accepted. At that edge its arrival bits clear and its phase bit flips. For one cycle the unit then drives that barrier's broadcast line, and it releases every processor that was held on that ID. If a wait names a barrier on which the processor has no outstanding arrival, that phase is already over, and the wait is released at once. An arrive that repeats an arrival already recorded in the same phase is dropped, and it sets a sticky error flag for the processor that sent it.

Top module: `split_barrier`

## Requirements
- R1: After reset, release_o, stall_o, bcast_o, phase_o and err_o are all zero.
- R2: An arrive never raises stall_o. stall_o[p] rises only in the cycle after a wait from processor p was sampled.
- R3: When the arrivals sampled at an edge make the arrival set of barrier b complete (all N_PROC processors), bcast_o[b] is high for exactly the next cycle, and phase_o[b] toggles at that edge. The arrival set is then empty.
- R4: Requests for one barrier ID never change the bcast_o or phase_o bit of any other ID.
- R5: A wait from processor p for a barrier on which p has an accepted arrival that has not yet completed holds the processor. stall_o[p] is high from the next cycle. In the cycle where bcast_o of that barrier is high, release_o[p] is high for one cycle and stall_o[p] is low.
- R6: A wait from processor p for a barrier on which p has no outstanding arrival gives release_o[p] high in the next cycle, and stall_o[p] stays low.
- R7: An arrive from processor p to a barrier where p's arrival is already recorded in the current phase is ignored: the arrival set, the phase and the completion are unchanged. err_o[p] goes high in the next cycle and stays high until reset.
- R8: An arrive and a wait from the same processor in the same cycle are handled with the arrive first. If the arrive completes the barrier, the release comes together with the broadcast. Otherwise the processor is held.
- R9: A wait from a processor that is already held is ignored.
- R10: Processor p drives arr_id_i[p*ID_W +: ID_W] and wt_id_i[p*ID_W +: ID_W], where ID_W = log2(N_BAR). Bit p of each per-processor vector and bit b of each per-barrier vector belong to processor p and barrier b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_vld_i | input | N_PROC | Arrive request per processor |
| arr_id_i | input | N_PROC*ID_W | Barrier ID of each arrive |
| wt_vld_i | input | N_PROC | Wait request per processor |
| wt_id_i | input | N_PROC*ID_W | Barrier ID of each wait |
| release_o | output | N_PROC | One-cycle release pulse per processor |
| stall_o | output | N_PROC | Processor is held by a pending wait |
| bcast_o | output | N_BAR | One-cycle completion broadcast per barrier |
| phase_o | output | N_BAR | Current phase bit per barrier |
| err_o | output | N_PROC | Sticky duplicate-arrive flag per processor |

## Verification
Every output of the unit is a register, so each effect of the requests sampled at an edge can be seen in the cycle that follows it. This covers the broadcast, the phase flip, an immediate or delayed release, the onset of a stall and the error flag. The bench drives requests just after the falling edge and updates its reference model for the coming rising edge. It compares all outputs at the next falling edge, which means one register stage after the stimulus. A held wait has no fixed latency. Its release is therefore checked against the cycle in which the model sees the barrier complete, and that is always the same cycle as the broadcast.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
   // width of a barrier ID, never below one bit
   function automatic int id_width(input int n_bar);
      return (n_bar > 1) ? $clog2(n_bar) : 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/barrier_slot.sv
// One named barrier: arrival set, phase bit, completion pulse.
module barrier_slot #(
   parameter int N_PROC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PROC-1:0] hit_i,      // arrives addressed here this cycle
   output logic [N_PROC-1:0] nxt_o,      // arrival set including this cycle
   output logic [N_PROC-1:0] dup_o,      // repeated arrivals, dropped
   output logic              done_now_o, // completes at the coming edge
   output logic              phase_o,
   output logic              bcast_o
);
   logic [N_PROC-1:0] arr_q;
   logic              phase_q;
   logic              bcast_q;

   always_comb begin
      dup_o      = hit_i & arr_q;
      nxt_o      = arr_q | hit_i;
      done_now_o = &nxt_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arr_q   <= '0;
         phase_q <= 1'b0;
         bcast_q <= 1'b0;
      end else begin
         arr_q   <= done_now_o ? '0 : nxt_o;
         phase_q <= phase_q ^ done_now_o;
         bcast_q <= done_now_o;
      end
   end

   assign phase_o = phase_q;
   assign bcast_o = bcast_q;
endmodule

// File: rtl/wait_track.sv
// Per-processor wait handling: immediate release or hold until completion.
module wait_track #(
   parameter int N_BAR = 4,
   parameter int ID_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wt_vld_i,
   input  logic [ID_W-1:0]  wt_id_i,
   input  logic [N_BAR-1:0] done_now_i,  // per barrier: completes at edge
   input  logic [N_BAR-1:0] mine_i,      // per barrier: own arrival outstanding
   output logic             release_o,
   output logic             stall_o
);
   logic            pend_q;
   logic [ID_W-1:0] pid_q;
   logic            rel_q;
   logic            rel_d, pend_d;
   logic [ID_W-1:0] pid_d;

   always_comb begin
      rel_d  = 1'b0;
      pend_d = pend_q;
      pid_d  = pid_q;
      if (pend_q) begin
         // held: new waits are ignored until this one is released
         if (done_now_i[pid_q]) begin
            rel_d  = 1'b1;
            pend_d = 1'b0;
         end
      end else if (wt_vld_i) begin
         if (done_now_i[wt_id_i] || !mine_i[wt_id_i]) begin
            rel_d = 1'b1;
         end else begin
            pend_d = 1'b1;
            pid_d  = wt_id_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pid_q  <= '0;
         rel_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         pid_q  <= pid_d;
         rel_q  <= rel_d;
      end
   end

   assign release_o = rel_q;
   assign stall_o   = pend_q;
endmodule

// File: rtl/split_barrier.sv
module split_barrier
   import barrier_pkg::*;
#(
   parameter int  N_PROC = 4,
   parameter int  N_BAR  = 4,
   localparam int ID_W   = id_width(N_BAR)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_PROC-1:0]      arr_vld_i,
   input  logic [N_PROC*ID_W-1:0] arr_id_i,
   input  logic [N_PROC-1:0]      wt_vld_i,
   input  logic [N_PROC*ID_W-1:0] wt_id_i,
   output logic [N_PROC-1:0]      release_o,
   output logic [N_PROC-1:0]      stall_o,
   output logic [N_BAR-1:0]       bcast_o,
   output logic [N_BAR-1:0]       phase_o,
   output logic [N_PROC-1:0]      err_o
);
   // elaboration-time parameter checks
   if (N_PROC < 2) begin : g_bad_proc
      $error("split_barrier: N_PROC must be at least 2");
   end
   if (N_BAR < 2 || !is_pow2(N_BAR)) begin : g_bad_bar
      $error("split_barrier: N_BAR must be a power of two, at least 2");
   end

   logic [N_PROC-1:0] hit_w  [N_BAR];
   logic [N_PROC-1:0] nxt_w  [N_BAR];
   logic [N_PROC-1:0] dup_w  [N_BAR];
   logic [N_BAR-1:0]  done_now_w;
   logic [N_BAR-1:0]  mine_w [N_PROC];
   logic [N_PROC-1:0] dup_any;
   logic [N_PROC-1:0] err_q;

   // decode arrivals per barrier and instantiate one slot each
   for (genvar b = 0; b < N_BAR; b++) begin : g_slot
      for (genvar p = 0; p < N_PROC; p++) begin : g_hit
         assign hit_w[b][p] = arr_vld_i[p] && (arr_id_i[p*ID_W +: ID_W] == ID_W'(b));
      end
      barrier_slot #(.N_PROC(N_PROC)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .hit_i      (hit_w[b]),
         .nxt_o      (nxt_w[b]),
         .dup_o      (dup_w[b]),
         .done_now_o (done_now_w[b]),
         .phase_o    (phase_o[b]),
         .bcast_o    (bcast_o[b])
      );
   end

   // transpose the arrival sets into per-processor views
   always_comb begin
      for (int p = 0; p < N_PROC; p++) begin
         for (int b = 0; b < N_BAR; b++) begin
            mine_w[p][b] = nxt_w[b][p];
         end
      end
   end

   always_comb begin
      dup_any = '0;
      for (int b = 0; b < N_BAR; b++) dup_any = dup_any | dup_w[b];
   end

   for (genvar p = 0; p < N_PROC; p++) begin : g_wait
      wait_track #(.N_BAR(N_BAR), .ID_W(ID_W)) u_wait (
         .clk        (clk),
         .rst_n      (rst_n),
         .wt_vld_i   (wt_vld_i[p]),
         .wt_id_i    (wt_id_i[p*ID_W +: ID_W]),
         .done_now_i (done_now_w),
         .mine_i     (mine_w[p]),
         .release_o  (release_o[p]),
         .stall_o    (stall_o[p])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= err_q | dup_any;
   end

   assign err_o = err_q;
endmodule

// File: rtl/split_barrier_chk.sv
module split_barrier_chk #(
   parameter int N_PROC = 4,
   parameter int N_BAR  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_PROC-1:0] wt_vld_i,
   input logic [N_PROC-1:0] release_o,
   input logic [N_PROC-1:0] stall_o,
   input logic [N_BAR-1:0]  bcast_o,
   input logic [N_BAR-1:0]  phase_o,
   input logic [N_PROC-1:0] err_o
);
   p_stall_needs_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o & ~$past(stall_o) & ~$past(wt_vld_i)) == '0);

   p_phase_flip_with_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o ^ $past(phase_o)) == bcast_o);

   p_hold_release_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o & release_o) == '0);

   p_stall_ends_in_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stall_o) & ~stall_o) == ($past(stall_o) & release_o));

   p_release_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o & ~$past(wt_vld_i | stall_o)) == '0);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_o) & ~err_o) == '0);
endmodule

bind split_barrier split_barrier_chk #(.N_PROC(N_PROC), .N_BAR(N_BAR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wt_vld_i  (wt_vld_i),
   .release_o (release_o),
   .stall_o   (stall_o),
   .bcast_o   (bcast_o),
   .phase_o   (phase_o),
   .err_o     (err_o)
);

// File: tb/split_barrier_tb_top.sv
module split_barrier_tb_top;
   localparam int NP = 4;
   localparam int NB = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    arr_vld = '0;
   logic [NP*IW-1:0] arr_id  = '0;
   logic [NP-1:0]    wt_vld  = '0;
   logic [NP*IW-1:0] wt_id   = '0;
   logic [NP-1:0] release_o, stall_o, err_o;
   logic [NB-1:0] bcast_o, phase_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   split_barrier #(.N_PROC(NP), .N_BAR(NB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .arr_vld_i(arr_vld), .arr_id_i(arr_id),
      .wt_vld_i(wt_vld), .wt_id_i(wt_id),
      .release_o(release_o), .stall_o(stall_o),
      .bcast_o(bcast_o), .phase_o(phase_o), .err_o(err_o)
   );

   // reference model state
   logic [NP-1:0] m_bits [NB];
   logic [NB-1:0] m_phase, m_bcast;
   logic [NP-1:0] m_pend, m_rel, m_err;
   int            m_pid [NP];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NB; b++) m_bits[b] = '0;
      m_phase = '0; m_bcast = '0; m_pend = '0; m_rel = '0; m_err = '0;
      for (int p = 0; p < NP; p++) m_pid[p] = 0;
   endtask

   // expected state after the coming rising edge
   task automatic model_step();
      logic [NP-1:0] nxt [NB];
      logic [NB-1:0] comp;
      for (int b = 0; b < NB; b++) begin
         nxt[b] = m_bits[b];
         for (int p = 0; p < NP; p++) begin
            if (arr_vld[p] && int'(arr_id[p*IW +: IW]) == b) begin
               if (m_bits[b][p]) m_err[p] = 1'b1;
               else nxt[b][p] = 1'b1;
            end
         end
         comp[b] = &nxt[b];
      end
      for (int p = 0; p < NP; p++) begin
         m_rel[p] = 1'b0;
         if (m_pend[p]) begin
            if (comp[m_pid[p]]) begin m_rel[p] = 1'b1; m_pend[p] = 1'b0; end
         end else if (wt_vld[p]) begin
            int id = int'(wt_id[p*IW +: IW]);
            if (comp[id] || !nxt[id][p]) m_rel[p] = 1'b1;
            else begin m_pend[p] = 1'b1; m_pid[p] = id; end
         end
      end
      for (int b = 0; b < NB; b++) m_bits[b] = comp[b] ? '0 : nxt[b];
      m_phase = m_phase ^ comp;
      m_bcast = comp;
   endtask

   task automatic clear_in();
      arr_vld = '0; arr_id = '0; wt_vld = '0; wt_id = '0;
   endtask

   task automatic arr(input int p, input int id);
      arr_vld[p] = 1'b1;
      arr_id[p*IW +: IW] = IW'(id);
   endtask

   task automatic wt(input int p, input int id);
      wt_vld[p] = 1'b1;
      wt_id[p*IW +: IW] = IW'(id);
   endtask

   // apply driven inputs for one edge and compare all outputs afterwards
   task automatic step();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(bcast_o == m_bcast, "R3 bcast", bcast_o, m_bcast);
      chk(phase_o == m_phase, "R3 phase", phase_o, m_phase);
      chk(release_o == m_rel, "R5 release", release_o, m_rel);
      chk(stall_o == m_pend, "R2 stall", stall_o, m_pend);
      chk(err_o == m_err, "R7 err", err_o, m_err);
      clear_in();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(negedge clk);
      chk({release_o, stall_o, bcast_o, phase_o, err_o} == '0, "R1 reset",
          int'({release_o, stall_o, bcast_o, phase_o, err_o}), 0);
      rst_n = 1'b1;

      // R10 / R3 / R4: all processors arrive at barrier 2 together
      for (int p = 0; p < NP; p++) arr(p, 2);
      step();
      chk(bcast_o == 4'b0100, "R10 bcast line of id 2", bcast_o, 4'b0100);
      chk(phase_o == 4'b0100, "R4 only id 2 phase moved", phase_o, 4'b0100);

      // R2 / R5: arrive, wait held, complete later
      arr(0, 1); step();
      chk(stall_o == '0, "R2 arrive does not stall", stall_o, 0);
      wt(0, 1); step();
      chk(stall_o[0] == 1'b1, "R5 wait held", stall_o, 1);
      arr(1, 1); arr(2, 1); step();
      chk(release_o == '0, "R5 no early release", release_o, 0);
      arr(3, 1); step();
      chk(release_o[0] && bcast_o[1] && !stall_o[0], "R5 release with bcast",
          {release_o, bcast_o}, 8'h12);

      // R6: wait with no outstanding arrival
      wt(0, 1); step();
      chk(release_o[0] && !stall_o[0], "R6 immediate release", release_o, 1);

      // R7: duplicate arrive
      arr(2, 0); step();
      arr(2, 0); step();
      chk(err_o == 4'b0100, "R7 err flag", err_o, 4'b0100);
      arr(0, 0); arr(1, 0); arr(3, 0); step();
      chk(bcast_o == 4'b0001, "R7 dup ignored, completes normally", bcast_o, 1);

      // R8 / R9
      arr(1, 3); wt(1, 3); step();
      chk(stall_o[1] == 1'b1, "R8 arrive before wait", stall_o, 2);
      wt(1, 0); step();
      chk(release_o[1] == 1'b0 && stall_o[1], "R9 second wait ignored", release_o, 0);
      arr(0, 3); arr(2, 3); arr(3, 3); step();
      chk(release_o[1] && bcast_o[3], "R8 held wait released", release_o, 2);
      arr(0, 2); arr(1, 2); arr(2, 2); step();
      arr(3, 2); wt(3, 2); step();
      chk(release_o[3] && bcast_o[2] && !stall_o[3], "R8 last arrive plus wait",
          release_o, 8);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < NP; p++) begin
            if ($urandom_range(3, 0) == 0) arr(p, $urandom_range(NB-1, 0));
            if ($urandom_range(7, 0) == 0) wt(p, $urandom_range(NB-1, 0));
         end
         step();
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule